// File: doc/BRIEF.md
# Programmable Asynchronous Character Framer

This block turns parallel characters into asynchronous serial frames and recovers characters from an incoming serial line. Each frame is a low start bit, five to eight data bits sent least significant bit first, an optional parity bit, and one, one-and-a-half or two high stop bits. The line rests high between frames. An external baud tick gates all bit timing, and one bit lasts `OSR` ticks (16 by default).

The transmitter accepts a byte through a valid/ready handshake. The receiver holds each recovered character until it is read and reports a parity error, framing error, overrun and line break as separate flags. A receive start edge that does not survive to the middle of the start bit is dropped. A loopback control routes the transmit stream straight into the receiver and keeps the external serial output at mark. With this path and a forced-low transmit line, break, framing, parity and overrun handling can be tested without any wiring.

Top module: `async_framer`

## Requirements
- R1: `cfg_len` selects the character length as 5 + `cfg_len` data bits (0→5, 1→6, 2→7, 3→8). A received character appears on the low bits of `rx_data`, and the unused upper bits are zero.
- R2: The line idles high. A frame begins with one low start bit, and the data bits follow least significant bit first. Each bit lasts 16 baud ticks.
- R3: When `cfg_par_en` is 1, a parity bit follows the data bits. It gives even parity when `cfg_par_odd` is 0 and odd parity when it is 1. The receiver sets `rx_perr` when the received parity bit disagrees with the configured parity.
- R4: The stop period is 16 ticks when `cfg_stop2` is 0. With `cfg_stop2` set it is 24 ticks for a 5-bit character and 32 ticks for 6, 7 or 8 bits. `tx_ready` returns high exactly 16·(1 + bits + parity) + stop ticks after the byte is accepted.
- R5: `tx_ready` is high only while the transmitter is idle. A byte is taken on a clock edge where `tx_valid` and `tx_ready` are both high, and the start bit goes out on the next cycle.
- R6: The receiver samples each bit at tick 8 of the bit. A start bit found high again at its tick-8 check is discarded, the receiver returns to idle, and no character is reported.
- R7: A stop bit sampled low sets `rx_ferr`. After that the receiver looks for no new start bit until the line has gone high again.
- R8: When the data, parity and stop positions are all sampled low, `rx_brk` is set together with `rx_ferr`, and the character is zero.
- R9: A character that completes while `rx_valid` is still high, with no `rx_read` in that cycle, replaces the held byte and sets `rx_oerr`. `rx_read` clears `rx_valid` and all four flags.
- R10: With `loopback` set, the transmit stream feeds the receiver internally, `txd` stays high and `rxd` is ignored.
- R11: `tx_break` forces the transmit line low for as long as it is held.
- R12: All bit timing advances only on cycles where `baud_tick` is high. A tick on every second cycle doubles every duration.
- R13: After reset `txd` is high, `tx_ready` is high and `rx_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | Oversampling enable, one pulse per baud tick |
| cfg_len | input | 2 | Character length select (5 + value bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_stop2 | input | 1 | Long stop period (1.5 bits for 5-bit characters, else 2 bits) |
| loopback | input | 1 | Route transmit stream into receiver, hold txd high |
| tx_break | input | 1 | Force transmit line low |
| tx_data | input | 8 | Byte to transmit (low bits used) |
| tx_valid | input | 1 | Byte offered |
| tx_ready | output | 1 | Transmitter idle, byte accepted this cycle if valid |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_data | output | 8 | Received character |
| rx_valid | output | 1 | Received character held and unread |
| rx_read | input | 1 | Consume the held character and its flags |
| rx_perr | output | 1 | Parity mismatch on held character |
| rx_ferr | output | 1 | Stop bit sampled low |
| rx_oerr | output | 1 | Previous character was overwritten unread |
| rx_brk | output | 1 | Whole character time was low |

## Verification
On the transmit side, the start bit goes out on the cycle after the accepting edge, and each later bit follows 16 ticks after the one before. The bench samples `txd` 8, 24, 40 ... cycles after acceptance, which lands in the middle of each bit. It also counts edges until `tx_ready` comes back and compares that count with the frame length from R4. A received character is due two synchroniser cycles plus 8 + 16·(bits + parity + 1) ticks after the falling start edge. The bench therefore waits for `rx_valid` inside a bounded window after the whole frame has been driven and reads the flags while the character is held. The tests for ignored input and for rejected starts watch `rx_valid` over a window longer than a full character.

// File: rtl/framer_pkg.sv
package framer_pkg;

    localparam int CHAR_MAX = 8;
    localparam int IDX_W    = $clog2(CHAR_MAX);

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_START,
        TX_DATA,
        TX_PAR,
        TX_STOP
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_HOLD
    } rx_state_e;

    typedef struct packed {
        logic [1:0] len_sel;
        logic       par_en;
        logic       par_odd;
        logic       stop2;
    } frame_cfg_t;

endpackage

// File: rtl/framer_tx.sv
module framer_tx
    import framer_pkg::*;
#(
    parameter int OSR = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  frame_cfg_t          cfg,
    input  logic                send_break,
    input  logic [CHAR_MAX-1:0] data,
    input  logic                valid,
    output logic                ready,
    output logic                line
);

    localparam int CW = $clog2(2 * OSR + 1);
    localparam logic [CW-1:0] BIT_END    = CW'(OSR - 1);
    localparam logic [CW-1:0] STOP15_END = CW'(OSR + OSR / 2 - 1);
    localparam logic [CW-1:0] STOP2_END  = CW'(2 * OSR - 1);

    typedef struct packed {
        tx_state_e           st;
        logic [CW-1:0]       cnt;
        logic [CHAR_MAX-1:0] sh;
        logic [IDX_W-1:0]    idx;
        logic                par;
    } tx_reg_t;

    tx_reg_t          r_d, r_q;
    logic [CW-1:0]    stop_end;
    logic [IDX_W-1:0] last_idx;
    logic             line_bit;

    always_comb begin
        stop_end = !cfg.stop2 ? BIT_END :
                   (cfg.len_sel == 2'd0 ? STOP15_END : STOP2_END);
        last_idx = IDX_W'(cfg.len_sel) + IDX_W'(4);
        r_d      = r_q;
        case (r_q.st)
            TX_IDLE: begin
                if (valid) begin
                    r_d.st  = TX_START;
                    r_d.cnt = '0;
                    r_d.sh  = data;
                    r_d.idx = '0;
                    r_d.par = cfg.par_odd;
                end
            end
            TX_START: begin
                if (tick) begin
                    if (r_q.cnt == BIT_END) begin
                        r_d.st  = TX_DATA;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            TX_DATA: begin
                if (tick) begin
                    if (r_q.cnt == BIT_END) begin
                        r_d.cnt = '0;
                        r_d.par = r_q.par ^ r_q.sh[0];
                        r_d.sh  = r_q.sh >> 1;
                        if (r_q.idx == last_idx) begin
                            r_d.st = cfg.par_en ? TX_PAR : TX_STOP;
                        end else begin
                            r_d.idx = r_q.idx + 1'b1;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            TX_PAR: begin
                if (tick) begin
                    if (r_q.cnt == BIT_END) begin
                        r_d.st  = TX_STOP;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            TX_STOP: begin
                if (tick) begin
                    if (r_q.cnt == stop_end) begin
                        r_d.st  = TX_IDLE;
                        r_d.cnt = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            default: r_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        case (r_q.st)
            TX_START: line_bit = 1'b0;
            TX_DATA:  line_bit = r_q.sh[0];
            TX_PAR:   line_bit = r_q.par;
            default:  line_bit = 1'b1;
        endcase
    end

    assign ready = (r_q.st == TX_IDLE);
    assign line  = line_bit && !send_break;

    // R5: an accepted byte puts the start bit on the line in the next cycle
    p_start_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ready) |=> (!line || send_break));

    // R2: an idle transmitter holds the line at mark
    p_idle_mark_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !send_break) |-> line);

    // R4: the cycle before the transmitter frees up is part of the stop period
    p_stop_mark_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ready) && !$past(send_break)) |-> $past(line));

endmodule

// File: rtl/framer_rx.sv
module framer_rx
    import framer_pkg::*;
#(
    parameter int OSR  = 16,
    parameter int SYNC = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  frame_cfg_t          cfg,
    input  logic                line_in,
    input  logic                rd,
    output logic [CHAR_MAX-1:0] data,
    output logic                valid,
    output logic                perr,
    output logic                ferr,
    output logic                oerr,
    output logic                brk
);

    localparam int CW = $clog2(OSR + 1);
    localparam logic [CW-1:0] BIT_END  = CW'(OSR - 1);
    localparam logic [CW-1:0] HALF_END = CW'(OSR / 2 - 1);

    typedef struct packed {
        logic [SYNC-1:0]     sync;
        rx_state_e           st;
        logic [CW-1:0]       cnt;
        logic [CHAR_MAX-1:0] sh;
        logic [IDX_W-1:0]    idx;
        logic                par;
        logic                pbit;
        logic [CHAR_MAX-1:0] data;
        logic                valid;
        logic                perr;
        logic                ferr;
        logic                oerr;
        logic                brk;
    } rx_reg_t;

    rx_reg_t          r_d, r_q;
    logic             rx_s;
    logic [IDX_W-1:0] last_idx;

    assign rx_s = r_q.sync[SYNC-1];

    always_comb begin
        last_idx = IDX_W'(cfg.len_sel) + IDX_W'(4);
        r_d      = r_q;
        r_d.sync = {r_q.sync[SYNC-2:0], line_in};
        if (rd) begin
            r_d.valid = 1'b0;
            r_d.perr  = 1'b0;
            r_d.ferr  = 1'b0;
            r_d.oerr  = 1'b0;
            r_d.brk   = 1'b0;
        end
        case (r_q.st)
            RX_IDLE: begin
                if (!rx_s) begin
                    r_d.st  = RX_START;
                    r_d.cnt = '0;
                end
            end
            RX_START: begin
                if (tick) begin
                    if (r_q.cnt == HALF_END) begin
                        if (rx_s) begin
                            r_d.st = RX_IDLE;
                        end else begin
                            r_d.st   = RX_DATA;
                            r_d.cnt  = '0;
                            r_d.idx  = '0;
                            r_d.sh   = '0;
                            r_d.par  = 1'b0;
                            r_d.pbit = 1'b0;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            RX_DATA: begin
                if (tick) begin
                    if (r_q.cnt == BIT_END) begin
                        r_d.cnt = '0;
                        r_d.sh  = {rx_s, r_q.sh[CHAR_MAX-1:1]};
                        r_d.par = r_q.par ^ rx_s;
                        if (r_q.idx == last_idx) begin
                            r_d.st = cfg.par_en ? RX_PAR : RX_STOP;
                        end else begin
                            r_d.idx = r_q.idx + 1'b1;
                        end
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            RX_PAR: begin
                if (tick) begin
                    if (r_q.cnt == BIT_END) begin
                        r_d.cnt  = '0;
                        r_d.pbit = rx_s;
                        r_d.st   = RX_STOP;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            RX_STOP: begin
                if (tick) begin
                    if (r_q.cnt == BIT_END) begin
                        r_d.cnt   = '0;
                        r_d.data  = r_q.sh >> (2'd3 - cfg.len_sel);
                        r_d.valid = 1'b1;
                        r_d.oerr  = r_q.valid && !rd;
                        r_d.perr  = cfg.par_en && (r_q.pbit != (r_q.par ^ cfg.par_odd));
                        r_d.ferr  = !rx_s;
                        r_d.brk   = !rx_s && (r_q.sh == '0) && !r_q.pbit;
                        r_d.st    = rx_s ? RX_IDLE : RX_HOLD;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end
            end
            RX_HOLD: begin
                if (rx_s) begin
                    r_d.st = RX_IDLE;
                end
            end
            default: r_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.sync <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    assign data  = r_q.data;
    assign valid = r_q.valid;
    assign perr  = r_q.perr;
    assign ferr  = r_q.ferr;
    assign oerr  = r_q.oerr;
    assign brk   = r_q.brk;

    // R8: a break is always also a framing error with an all-zero character
    p_brk_ferr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.brk |-> (r_q.ferr && r_q.data == '0));

    // R9: an overrun is only ever reported alongside a held character
    p_overrun_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        r_q.oerr |-> r_q.valid);

endmodule

// File: rtl/async_framer.sv
module async_framer
    import framer_pkg::*;
#(
    parameter int OSR  = 16,
    parameter int SYNC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       baud_tick,
    input  logic [1:0] cfg_len,
    input  logic       cfg_par_en,
    input  logic       cfg_par_odd,
    input  logic       cfg_stop2,
    input  logic       loopback,
    input  logic       tx_break,
    input  logic [7:0] tx_data,
    input  logic       tx_valid,
    output logic       tx_ready,
    output logic       txd,
    input  logic       rxd,
    output logic [7:0] rx_data,
    output logic       rx_valid,
    input  logic       rx_read,
    output logic       rx_perr,
    output logic       rx_ferr,
    output logic       rx_oerr,
    output logic       rx_brk
);

    frame_cfg_t cfg;
    logic       tx_line;
    logic       rx_line;

    assign cfg     = '{len_sel: cfg_len, par_en: cfg_par_en,
                       par_odd: cfg_par_odd, stop2: cfg_stop2};
    assign rx_line = loopback ? tx_line : rxd;
    assign txd     = loopback ? 1'b1 : tx_line;

    framer_tx #(.OSR(OSR)) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (baud_tick),
        .cfg        (cfg),
        .send_break (tx_break),
        .data       (tx_data),
        .valid      (tx_valid),
        .ready      (tx_ready),
        .line       (tx_line)
    );

    framer_rx #(.OSR(OSR), .SYNC(SYNC)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (baud_tick),
        .cfg     (cfg),
        .line_in (rx_line),
        .rd      (rx_read),
        .data    (rx_data),
        .valid   (rx_valid),
        .perr    (rx_perr),
        .ferr    (rx_ferr),
        .oerr    (rx_oerr),
        .brk     (rx_brk)
    );

endmodule

// File: tb/async_framer_bench.sv
`timescale 1ns/100ps
module async_framer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_tick = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_stop2 = 1'b0;
    logic       loopback = 1'b0;
    logic       tx_break = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       tx_valid = 1'b0;
    logic       tx_ready;
    logic       txd;
    logic       rxd = 1'b1;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       rx_read = 1'b0;
    logic       rx_perr, rx_ferr, rx_oerr, rx_brk;

    int n_chk = 0;
    int n_fail = 0;
    int tick_div = 1;

    async_framer u_async_framer (
        .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_stop2(cfg_stop2), .loopback(loopback), .tx_break(tx_break),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd),
        .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid), .rx_read(rx_read),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_oerr(rx_oerr), .rx_brk(rx_brk)
    );

    always #2.5 clk = ~clk;

    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (tick_div == 1) baud_tick = 1'b1;
            else               baud_tick = ~baud_tick;
        end
    end

    typedef struct packed {
        logic [1:0] len;
        logic       pen;
        logic       podd;
        logic       s2;
        logic [7:0] data;
        logic [15:0] cyc;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{2'd0, 1'b0, 1'b0, 1'b0, 8'h15, 16'd112},
        '{2'd0, 1'b1, 1'b1, 1'b1, 8'h0A, 16'd136},
        '{2'd1, 1'b1, 1'b0, 1'b0, 8'h2C, 16'd144},
        '{2'd2, 1'b0, 1'b0, 1'b1, 8'h55, 16'd160},
        '{2'd3, 1'b1, 1'b1, 1'b1, 8'hA7, 16'd192},
        '{2'd3, 1'b0, 1'b0, 1'b0, 8'hFF, 16'd160},
        '{2'd3, 1'b1, 1'b0, 1'b0, 8'h00, 16'd176},
        '{2'd0, 1'b0, 1'b0, 1'b1, 8'h1F, 16'd120}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input logic [1:0] l, input logic pe, input logic po, input logic s2);
        @(posedge clk); #1;
        cfg_len = l; cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = s2;
    endtask

    task automatic tx_send(input logic [7:0] d, output int cyc, output bit txd_high);
        @(posedge clk); #1;
        tx_data = d; tx_valid = 1'b1;
        @(posedge clk); #1;
        tx_valid = 1'b0;
        cyc = 0;
        txd_high = 1'b1;
        do begin
            @(posedge clk); #1;
            cyc++;
            if (txd !== 1'b1) txd_high = 1'b0;
        end while (!tx_ready && cyc < 2000);
    endtask

    task automatic drive_bit(input logic b);
        @(posedge clk); #1;
        rxd = b;
        repeat (15) @(posedge clk);
    endtask

    task automatic rx_frame(input logic [7:0] d, input int n, input bit pen,
                            input bit pbit, input bit stopb);
        drive_bit(1'b0);
        for (int i = 0; i < n; i++) drive_bit(d[i]);
        if (pen) drive_bit(pbit);
        drive_bit(stopb);
        @(posedge clk); #1;
        rxd = 1'b1;
        repeat (32) @(posedge clk);
        #1;
    endtask

    task automatic wait_rx(output bit got);
        got = 1'b0;
        for (int i = 0; i < 600; i++) begin
            if (rx_valid === 1'b1) begin
                got = 1'b1;
                break;
            end
            @(posedge clk); #1;
        end
    endtask

    task automatic rd_pulse;
        @(posedge clk); #1;
        rx_read = 1'b1;
        @(posedge clk); #1;
        rx_read = 1'b0;
    endtask

    function automatic logic even_par(input logic [7:0] d, input int n);
        logic p = 1'b0;
        for (int i = 0; i < n; i++) p ^= d[i];
        return p;
    endfunction

    bit done_flag = 1'b0;

    initial begin
        #(190000 * 5);
        if (!done_flag) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int  cyc;
        bit  high;
        bit  got;
        logic [10:0] exp_bits;

        repeat (4) @(posedge clk);
        #1;
        // R13: reset state
        check(txd === 1'b1, "R13", "txd in reset", txd, 1);
        check(tx_ready === 1'b1, "R13", "tx_ready in reset", tx_ready, 1);
        check(rx_valid === 1'b0, "R13", "rx_valid in reset", rx_valid, 0);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);

        // Table walk in loopback: frame length (R4), data recovery (R1), parity (R3), quiet txd (R10)
        loopback = 1'b1;
        for (int v = 0; v < 8; v++) begin
            set_cfg(VEC[v].len, VEC[v].pen, VEC[v].podd, VEC[v].s2);
            tx_send(VEC[v].data, cyc, high);
            check(cyc == int'(VEC[v].cyc), "R4", "frame length in cycles", cyc, VEC[v].cyc);
            check(high, "R10", "txd high during loopback", high, 1);
            wait_rx(got);
            check(got, "R1", "loopback character arrived", got, 1);
            check(rx_data === VEC[v].data, "R1", "loopback data", rx_data, VEC[v].data);
            check(rx_perr === 1'b0, "R3", "no parity error", rx_perr, 0);
            check(rx_ferr === 1'b0, "R7", "no framing error", rx_ferr, 0);
            rd_pulse();
            check(rx_valid === 1'b0, "R9", "read clears rx_valid", rx_valid, 0);
        end

        // R2, R3: txd waveform, 8 bits, odd parity, byte B4
        loopback = 1'b0;
        set_cfg(2'd3, 1'b1, 1'b1, 1'b0);
        exp_bits = {1'b1, ~even_par(8'hB4, 8), 8'hB4, 1'b0};
        @(posedge clk); #1;
        tx_data = 8'hB4; tx_valid = 1'b1;
        @(posedge clk); #1;
        tx_valid = 1'b0;
        check(tx_ready === 1'b0, "R5", "tx_ready low after accept", tx_ready, 0);
        repeat (7) @(posedge clk);
        #1;
        for (int b = 0; b < 11; b++) begin
            check(txd === exp_bits[b], "R2", "txd mid-bit value", txd, exp_bits[b]);
            repeat (16) @(posedge clk);
            #1;
        end
        repeat (40) @(posedge clk);
        #1;
        check(tx_ready === 1'b1 && txd === 1'b1, "R2", "idle high after frame", txd, 1);

        // R3: wrong even parity received
        set_cfg(2'd3, 1'b1, 1'b0, 1'b0);
        rx_frame(8'h3C, 8, 1'b1, 1'b1, 1'b1);
        wait_rx(got);
        check(got && rx_perr === 1'b1, "R3", "parity error flagged", rx_perr, 1);
        check(rx_data === 8'h3C, "R3", "data with parity error", rx_data, 8'h3C);
        rd_pulse();

        // R3, R1: correct odd parity, 7 bits
        set_cfg(2'd2, 1'b1, 1'b1, 1'b0);
        rx_frame(8'h41, 7, 1'b1, ~even_par(8'h41, 7), 1'b1);
        wait_rx(got);
        check(got && rx_perr === 1'b0, "R3", "odd parity accepted", rx_perr, 0);
        check(rx_data === 8'h41, "R1", "7-bit data", rx_data, 8'h41);
        rd_pulse();

        // R7: framing error
        set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
        rx_frame(8'h5A, 8, 1'b0, 1'b0, 1'b0);
        wait_rx(got);
        check(got && rx_ferr === 1'b1, "R7", "framing error flagged", rx_ferr, 1);
        check(rx_brk === 1'b0, "R8", "no break on nonzero data", rx_brk, 0);
        check(rx_data === 8'h5A, "R7", "data with framing error", rx_data, 8'h5A);
        rd_pulse();

        // R8, R7: external break held long, then single character only
        set_cfg(2'd1, 1'b1, 1'b0, 1'b0);
        @(posedge clk); #1;
        rxd = 1'b0;
        repeat (400) @(posedge clk);
        #1;
        wait_rx(got);
        check(got && rx_brk === 1'b1, "R8", "break flagged", rx_brk, 1);
        check(rx_ferr === 1'b1, "R8", "break implies framing error", rx_ferr, 1);
        check(rx_data === 8'h00, "R8", "break data zero", rx_data, 0);
        rd_pulse();
        repeat (300) @(posedge clk);
        #1;
        check(rx_valid === 1'b0, "R7", "no new start while line low", rx_valid, 0);
        rxd = 1'b1;
        repeat (40) @(posedge clk);
        #1;

        // R6: false start rejected, then next character received
        set_cfg(2'd3, 1'b0, 1'b0, 1'b0);
        rxd = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        rxd = 1'b1;
        repeat (300) @(posedge clk);
        #1;
        check(rx_valid === 1'b0, "R6", "false start discarded", rx_valid, 0);
        rx_frame(8'h6E, 8, 1'b0, 1'b0, 1'b1);
        wait_rx(got);
        check(got && rx_data === 8'h6E, "R6", "char after false start", rx_data, 8'h6E);
        rd_pulse();

        // R9: overrun
        rx_frame(8'h11, 8, 1'b0, 1'b0, 1'b1);
        rx_frame(8'h22, 8, 1'b0, 1'b0, 1'b1);
        check(rx_valid === 1'b1 && rx_oerr === 1'b1, "R9", "overrun flagged", rx_oerr, 1);
        check(rx_data === 8'h22, "R9", "newest byte kept", rx_data, 8'h22);
        rd_pulse();
        check(rx_oerr === 1'b0 && rx_valid === 1'b0, "R9", "read clears overrun", rx_oerr, 0);
        rx_frame(8'h33, 8, 1'b0, 1'b0, 1'b1);
        check(rx_valid === 1'b1 && rx_oerr === 1'b0, "R9", "no overrun after read", rx_oerr, 0);
        rd_pulse();

        // R10: rxd ignored in loopback
        loopback = 1'b1;
        rxd = 1'b0;
        repeat (300) @(posedge clk);
        #1;
        check(rx_valid === 1'b0, "R10", "rxd ignored in loopback", rx_valid, 0);
        check(txd === 1'b1, "R10", "txd high in loopback", txd, 1);
        rxd = 1'b1;

        // R11: tx_break on external line
        loopback = 1'b0;
        tx_break = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check(txd === 1'b0, "R11", "break drives txd low", txd, 0);
        tx_break = 1'b0;
        @(posedge clk); #1;
        check(txd === 1'b1, "R11", "txd high after break", txd, 1);

        // R11, R8: break injected through loopback
        loopback = 1'b1;
        set_cfg(2'd3, 1'b1, 1'b0, 1'b0);
        tx_break = 1'b1;
        repeat (400) @(posedge clk);
        #1;
        tx_break = 1'b0;
        wait_rx(got);
        check(got && rx_brk === 1'b1, "R11", "loopback break received", rx_brk, 1);
        check(rx_perr === 1'b0, "R8", "zero parity bit fits even", rx_perr, 0);
        rd_pulse();
        repeat (300) @(posedge clk);
        #1;
        check(rx_valid === 1'b0, "R8", "one character per break", rx_valid, 0);

        // R12: tick every other cycle doubles the frame
        tick_div = 2;
        set_cfg(2'd0, 1'b0, 1'b0, 1'b0);
        tx_send(8'h09, cyc, high);
        check(cyc >= 222 && cyc <= 225, "R12", "half-rate frame length", cyc, 224);
        wait_rx(got);
        check(got && rx_data === 8'h09, "R12", "half-rate data", rx_data, 8'h09);
        rd_pulse();
        tick_div = 1;

        done_flag = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule